// File: doc/BRIEF.md
# Suspendable Sequential Divider

This block divides a 32-bit or 16-bit dividend by a 16-bit divisor. Operands can be signed (two's complement) or unsigned, and they can be read as integers or as fractions. The work is done one step per enabled clock cycle, on a fixed schedule of 19 steps. A start pulse is the first step. It loads the operands and works out their magnitudes. Sixteen non-restoring iterations follow. After them come one remainder-correction step and one sign fix-up step, which writes the quotient, the remainder and the flags.

All partial results sit in registers. A caller can pause the operation by dropping the step enable between any two steps. It continues later with no loss of state, which lets an enclosing sequencer service other work in the middle of a divide. The quotient and remainder are both 16 bits wide in every mode. An overflow flag shows that the true quotient does not fit in 16 bits. A separate flag reports a zero divisor.

Top module: `iter_divider`

## Requirements
- R1: `start` is accepted only while `busy` is low. It captures the operands and mode pins, and `busy` is high from the next cycle. A `start` pulse while `busy` is high has no effect on the result in progress.
- R2: A divide takes the start cycle plus exactly 18 cycles with `step_en` high. On the last of these, `busy` falls and `done` is high for exactly one cycle.
- R3: While `busy` is high and `step_en` is low, no internal or output state changes, and completion is delayed by one cycle per stalled cycle.
- R4: With `is_signed`=0, `is_frac`=0 and `is_wide`=1, the 32-bit dividend is divided as unsigned. The quotient is the truncated quotient and the remainder is dividend minus quotient times divisor.
- R5: With `is_signed`=1, operands are two's complement. The quotient truncates toward zero and a nonzero remainder has the sign of the dividend.
- R6: With `is_wide`=0 and `is_frac`=0, only `dividend[15:0]` is used. It is sign-extended when signed and zero-extended when unsigned, and `dividend[31:16]` has no effect.
- R7: With `is_frac`=1, only `dividend[15:0]` is used and `is_wide` has no effect. Signed mode treats both operands as 1.15 values and computes dividend·2^15/divisor. Unsigned mode treats them as 0.16 values and computes dividend·2^16/divisor. The remainder follows the rule of R4/R5 on the scaled dividend.
- R8: `overflow` is set when the exact truncated quotient is not representable. Unsigned results must lie in 0..65535 and signed results in -32768..32767. The quotient and remainder are then unspecified.
- R9: A zero divisor sets `div_zero` and clears `overflow`. The quotient is then all ones and the remainder is zero.
- R10: Reset clears `busy`, `done`, both flags, the quotient and the remainder. Outputs change only on the cycle that `done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a divide (first step) when idle |
| step_en | input | 1 | Advance one step of the running divide |
| is_signed | input | 1 | 1: two's complement operands |
| is_frac | input | 1 | 1: fractional interpretation |
| is_wide | input | 1 | 1: 32-bit dividend (integer mode only) |
| dividend | input | 32 | Dividend |
| divisor | input | 16 | Divisor |
| busy | output | 1 | Divide in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 16 | Quotient of the last completed divide |
| remainder | output | 16 | Remainder of the last completed divide |
| div_zero | output | 1 | Last divide had a zero divisor |
| overflow | output | 1 | Last quotient was not representable |

## Verification
The assertions assume that `start` and `step_en` are synchronous and free of unknowns after reset. They do not assume that the caller holds off `start` while busy. The bench raises `start` on purpose in the middle of some divides, so the ignore rule is exercised. Operand and mode pins are only required to be valid in the cycle `start` is accepted. The bench changes them freely afterwards so that any dependence on them later would show up. The stimulus sweeps corner operands over all eight mode combinations with random stall patterns. These corners include the extremes of each sign, a zero divisor, and quotients at the edge of the representable range.

// File: rtl/iter_div_pkg.sv
// Shared definitions for the sequential divider.
// Assumes the step counter encodes phase as: 1..W iterate, W+1 correct, W+2 fix up.
package iter_div_pkg;

    // Phase of the running divide, decoded from the step counter
    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ITER,
        PH_CORR,
        PH_FIX
    } div_phase_t;

    // Captured operating mode
    typedef struct packed {
        logic sgn;
        logic frac;
        logic wide;
    } div_mode_t;

endpackage

// File: rtl/iter_div_prep.sv
// Operand preparation: builds the unsigned 2W-bit numerator and W-bit denominator
// magnitudes, the result sign controls, and the early zero/overflow indications.
// Assumes W >= 2. Purely combinational; used only on the start step.
module iter_div_prep
    import iter_div_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [2*W-1:0] dividend,
    input  logic [W-1:0]   divisor,
    input  div_mode_t      mode,
    output logic [2*W-1:0] num_mag,
    output logic [W-1:0]   den_mag,
    output logic           neg_q,
    output logic           neg_r,
    output logic           den_zero,
    output logic           pre_ovf
);
    logic [W-1:0]   lo_part;
    logic [W-1:0]   lo_mag;
    logic [2*W-1:0] full_mag;
    logic           lo_neg;
    logic           full_neg;
    logic           a_neg;
    logic           b_neg;

    // Signs and magnitudes of the dividend in its short and long readings
    always_comb begin
        lo_part  = dividend[W-1:0];
        lo_neg   = mode.sgn & lo_part[W-1];
        full_neg = mode.sgn & dividend[2*W-1];
        lo_mag   = lo_neg ? (~lo_part + 1'b1) : lo_part;
        full_mag = full_neg ? (~dividend + 1'b1) : dividend;
        a_neg    = (mode.frac || !mode.wide) ? lo_neg : full_neg;
    end

    // Numerator selection by mode: fractional scaling, long or short integer
    always_comb begin
        if (mode.frac) begin
            if (mode.sgn) num_mag = {1'b0, lo_mag, {(W-1){1'b0}}};
            else          num_mag = {lo_mag, {W{1'b0}}};
        end else if (mode.wide) begin
            num_mag = full_mag;
        end else begin
            num_mag = {{W{1'b0}}, lo_mag};
        end
    end

    // Divisor magnitude, sign controls and early range check
    always_comb begin
        b_neg    = mode.sgn & divisor[W-1];
        den_mag  = b_neg ? (~divisor + 1'b1) : divisor;
        den_zero = (divisor == '0);
        neg_q    = a_neg ^ b_neg;
        neg_r    = a_neg;
        pre_ovf  = !den_zero && (num_mag[2*W-1:W] >= den_mag);
    end
endmodule

// File: rtl/iter_div_step.sv
// One non-restoring division iteration plus the final remainder correction.
// Partial remainder is W+2 bits two's complement; the quotient register shifts
// remaining dividend bits out at the top and quotient bits in at the bottom.
// Assumes the partial remainder stays within [-den, den). Combinational.
module iter_div_step #(
    parameter int W  = 16,
    parameter int PW = W + 2
) (
    input  logic [PW-1:0] prem,
    input  logic [W-1:0]  qreg,
    input  logic [W-1:0]  den,
    output logic [PW-1:0] prem_next,
    output logic [W-1:0]  qreg_next,
    output logic [PW-1:0] prem_corr
);
    logic [PW-1:0] shifted;
    logic [PW-1:0] den_ext;

    // Shift in the next dividend bit, then add or subtract by current sign
    always_comb begin
        den_ext   = {{(PW-W){1'b0}}, den};
        shifted   = {prem[PW-2:0], qreg[W-1]};
        prem_next = prem[PW-1] ? (shifted + den_ext) : (shifted - den_ext);
        qreg_next = {qreg[W-2:0], ~prem_next[PW-1]};
    end

    // Restore a negative final partial remainder
    always_comb begin
        prem_corr = prem[PW-1] ? (prem + den_ext) : prem;
    end
endmodule

// File: rtl/iter_div_fix.sv
// Final sign fix-up: applies result signs, checks signed representability,
// and forces a fixed result on a zero divisor.
// Assumes qmag/rmag are the unsigned quotient and corrected remainder. Combinational.
module iter_div_fix #(
    parameter int W = 16
) (
    input  logic [W-1:0] qmag,
    input  logic [W-1:0] rmag,
    input  logic         neg_q,
    input  logic         neg_r,
    input  logic         sgn,
    input  logic         den_zero,
    input  logic         pre_ovf,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem,
    output logic         zero_flag,
    output logic         ovf_flag
);
    localparam logic [W-1:0] HALF = {1'b1, {(W-1){1'b0}}};

    logic sgn_ovf;

    // Signed range test: magnitude may reach HALF only for a negative result
    always_comb begin
        sgn_ovf = sgn && (neg_q ? (qmag > HALF) : (qmag >= HALF));
    end

    // Result and flag selection
    always_comb begin
        zero_flag = den_zero;
        ovf_flag  = !den_zero && (pre_ovf || sgn_ovf);
        if (den_zero) begin
            quo = '1;
            rem = '0;
        end else begin
            quo = neg_q ? (~qmag + 1'b1) : qmag;
            rem = neg_r ? (~rmag + 1'b1) : rmag;
        end
    end
endmodule

// File: rtl/iter_divider.sv
// Suspendable sequential divider, top level.
// Runs a fixed 19-step schedule: load on start, W iterations, correction, fix-up.
// Every step after load needs step_en; with step_en low all state holds.
// Assumes start/step_en are synchronous; operands are sampled only on accepted start.
module iter_divider
    import iter_div_pkg::*;
#(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           step_en,
    input  logic           is_signed,
    input  logic           is_frac,
    input  logic           is_wide,
    input  logic [2*W-1:0] dividend,
    input  logic [W-1:0]   divisor,
    output logic           busy,
    output logic           done,
    output logic [W-1:0]   quotient,
    output logic [W-1:0]   remainder,
    output logic           div_zero,
    output logic           overflow
);
    localparam int STEPS = W + 3;
    localparam int CW    = $clog2(STEPS);
    localparam int PW    = W + 2;
    localparam logic [CW-1:0] LAST_ITER = CW'(W);
    localparam logic [CW-1:0] CORR_STEP = CW'(W + 1);
    localparam logic [CW-1:0] FIX_STEP  = CW'(W + 2);

    div_mode_t      mode_in;
    logic [2*W-1:0] num_mag;
    logic [W-1:0]   den_mag;
    logic           p_neg_q;
    logic           p_neg_r;
    logic           p_zero;
    logic           p_ovf;

    logic [CW-1:0]  step_cnt;
    logic [PW-1:0]  prem;
    logic [W-1:0]   qreg;
    logic [W-1:0]   den_r;
    logic           neg_q_r;
    logic           neg_r_r;
    logic           sgn_r;
    logic           zero_r;
    logic           povf_r;

    logic [PW-1:0]  prem_next;
    logic [W-1:0]   qreg_next;
    logic [PW-1:0]  prem_corr;
    logic [W-1:0]   fx_quo;
    logic [W-1:0]   fx_rem;
    logic           fx_zero;
    logic           fx_ovf;
    div_phase_t     phase;

    // Gather mode pins into the shared struct
    always_comb begin
        mode_in = '{sgn: is_signed, frac: is_frac, wide: is_wide};
    end

    iter_div_prep #(.W(W)) u_prep (
        .dividend (dividend),
        .divisor  (divisor),
        .mode     (mode_in),
        .num_mag  (num_mag),
        .den_mag  (den_mag),
        .neg_q    (p_neg_q),
        .neg_r    (p_neg_r),
        .den_zero (p_zero),
        .pre_ovf  (p_ovf)
    );

    iter_div_step #(.W(W), .PW(PW)) u_step (
        .prem      (prem),
        .qreg      (qreg),
        .den       (den_r),
        .prem_next (prem_next),
        .qreg_next (qreg_next),
        .prem_corr (prem_corr)
    );

    iter_div_fix #(.W(W)) u_fix (
        .qmag      (qreg),
        .rmag      (prem[W-1:0]),
        .neg_q     (neg_q_r),
        .neg_r     (neg_r_r),
        .sgn       (sgn_r),
        .den_zero  (zero_r),
        .pre_ovf   (povf_r),
        .quo       (fx_quo),
        .rem       (fx_rem),
        .zero_flag (fx_zero),
        .ovf_flag  (fx_ovf)
    );

    // Decode the step counter into the current phase
    always_comb begin
        if (!busy)                        phase = PH_IDLE;
        else if (step_cnt <= LAST_ITER)   phase = PH_ITER;
        else if (step_cnt == CORR_STEP)   phase = PH_CORR;
        else                              phase = PH_FIX;
    end

    // Step sequencer and architectural state; holds everything when not stepping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            done      <= 1'b0;
            step_cnt  <= '0;
            prem      <= '0;
            qreg      <= '0;
            den_r     <= '0;
            neg_q_r   <= 1'b0;
            neg_r_r   <= 1'b0;
            sgn_r     <= 1'b0;
            zero_r    <= 1'b0;
            povf_r    <= 1'b0;
            quotient  <= '0;
            remainder <= '0;
            div_zero  <= 1'b0;
            overflow  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy     <= 1'b1;
                    step_cnt <= CW'(1);
                    prem     <= {{(PW-W){1'b0}}, num_mag[2*W-1:W]};
                    qreg     <= num_mag[W-1:0];
                    den_r    <= den_mag;
                    neg_q_r  <= p_neg_q;
                    neg_r_r  <= p_neg_r;
                    sgn_r    <= is_signed;
                    zero_r   <= p_zero;
                    povf_r   <= p_ovf;
                end
            end else if (step_en) begin
                case (phase)
                    PH_ITER: begin
                        prem     <= prem_next;
                        qreg     <= qreg_next;
                        step_cnt <= step_cnt + 1'b1;
                    end
                    PH_CORR: begin
                        prem     <= prem_corr;
                        step_cnt <= step_cnt + 1'b1;
                    end
                    PH_FIX: begin
                        quotient  <= fx_quo;
                        remainder <= fx_rem;
                        div_zero  <= fx_zero;
                        overflow  <= fx_ovf;
                        busy      <= 1'b0;
                        done      <= 1'b1;
                        step_cnt  <= '0;
                    end
                    default: begin
                        step_cnt <= '0;
                    end
                endcase
            end
        end
    end
endmodule

// Temporal checks for the sequential divider, attached by bind below.
module iter_divider_chk #(
    parameter int W  = 16,
    parameter int CW = 5,
    parameter int PW = W + 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          step_en,
    input logic          busy,
    input logic          done,
    input logic [W-1:0]  quotient,
    input logic [W-1:0]  remainder,
    input logic          div_zero,
    input logic          overflow,
    input logic [CW-1:0] step_cnt,
    input logic [PW-1:0] prem,
    input logic [W-1:0]  qreg
);
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> busy); // R1
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R2
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && $past(busy)); // R2
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (step_cnt >= CW'(1)) && (step_cnt <= CW'(W + 2))); // R2
    AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !step_en |=> busy && $stable(step_cnt) && $stable(prem) && $stable(qreg)); // R3
    AST_ZERO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        div_zero |-> !overflow && (quotient == '1) && (remainder == '0)); // R9
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(quotient) && $stable(remainder) && $stable(div_zero) && $stable(overflow)); // R10
endmodule

bind iter_divider iter_divider_chk #(.W(W), .CW(CW), .PW(PW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .step_en   (step_en),
    .busy      (busy),
    .done      (done),
    .quotient  (quotient),
    .remainder (remainder),
    .div_zero  (div_zero),
    .overflow  (overflow),
    .step_cnt  (step_cnt),
    .prem      (prem),
    .qreg      (qreg)
);

// File: tb/iter_divider_test.sv
// Sweep bench: corner operands across all eight mode combinations with random
// stalls, plus random operands; expected results computed with 64-bit arithmetic.
module iter_divider_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        step_en = 1'b0;
    logic        is_signed = 1'b0;
    logic        is_frac = 1'b0;
    logic        is_wide = 1'b0;
    logic [31:0] dividend = '0;
    logic [15:0] divisor = '0;
    logic        busy;
    logic        done;
    logic [15:0] quotient;
    logic [15:0] remainder;
    logic        div_zero;
    logic        overflow;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    iter_divider uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .step_en   (step_en),
        .is_signed (is_signed),
        .is_frac   (is_frac),
        .is_wide   (is_wide),
        .dividend  (dividend),
        .divisor   (divisor),
        .busy      (busy),
        .done      (done),
        .quotient  (quotient),
        .remainder (remainder),
        .div_zero  (div_zero),
        .overflow  (overflow)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Arithmetic model of the requirements R4..R9
    task automatic model(input logic [31:0] a, input logic [15:0] b, input bit sg, input bit fr,
                         input bit wd, output logic [15:0] q, output logic [15:0] r,
                         output bit z, output bit ov);
        longint num;
        longint den;
        longint qq;
        longint rr;
        logic signed [31:0] a_s;
        logic signed [15:0] a_ls;
        logic signed [15:0] b_s;
        a_s  = a;
        a_ls = a[15:0];
        b_s  = b;
        if (fr)      num = sg ? longint'(a_ls) * 32768 : longint'(a[15:0]) * 65536;
        else if (wd) num = sg ? longint'(a_s) : longint'(a);
        else         num = sg ? longint'(a_ls) : longint'(a[15:0]);
        den = sg ? longint'(b_s) : longint'(b);
        if (den == 0) begin
            z = 1'b1; ov = 1'b0; q = 16'hFFFF; r = 16'h0000;
        end else begin
            qq = num / den;
            rr = num % den;
            z  = 1'b0;
            ov = sg ? (qq > 32767 || qq < -32768) : (qq > 65535);
            q  = qq[15:0];
            r  = rr[15:0];
        end
    endtask

    // One divide with stall percentage; optionally pokes start mid-run
    task automatic run_div(input logic [31:0] a, input logic [15:0] b, input bit sg,
                           input bit fr, input bit wd, input int stall_pct, input bit poke);
        logic [15:0] eq;
        logic [15:0] er;
        bit          ez;
        bit          eo;
        int          en_cnt;
        int          guard;
        bit          frozen_ok;
        logic [15:0] q_before;
        bit          was_busy;
        bit          was_en;
        model(a, b, sg, fr, wd, eq, er, ez, eo);
        @(negedge clk);
        dividend = a; divisor = b; is_signed = sg; is_frac = fr; is_wide = wd;
        start = 1'b1; step_en = 1'b0;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R1 busy after start", busy, 1);
        en_cnt = 0; guard = 0; frozen_ok = 1'b1;
        while (done !== 1'b1 && guard < 400) begin
            step_en   = ($urandom % 100) >= stall_pct;
            dividend  = $urandom; divisor = $urandom[15:0];
            is_signed = $urandom; is_frac = $urandom; is_wide = $urandom;
            start     = poke && (en_cnt == 5);
            was_busy  = busy;
            was_en    = step_en;
            q_before  = quotient;
            @(negedge clk);
            start = 1'b0;
            if (was_busy && was_en) en_cnt++;
            if (was_busy && !was_en && (busy !== 1'b1 || quotient !== q_before || done === 1'b1))
                frozen_ok = 1'b0;
            guard++;
        end
        step_en = 1'b0;
        chk(frozen_ok, "R3 stall freezes", 0, 1);
        chk(en_cnt == 18 && busy === 1'b0, "R2 step count", en_cnt, 18);
        chk(div_zero === ez, "R9 div_zero", div_zero, ez);
        chk(overflow === eo, "R8 overflow", overflow, eo);
        if (!eo) begin
            chk(quotient === eq, fr ? "R7 quotient" : (sg ? "R5 quotient" : "R4 quotient"), quotient, eq);
            chk(remainder === er, wd ? "R4 remainder" : "R6 remainder", remainder, er);
        end
        @(negedge clk);
        chk(done === 1'b0, "R2 done single cycle", done, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] dv [12];
        logic [15:0] ds [10];
        dv = '{32'h0000_0000, 32'h0000_0001, 32'h0000_7FFF, 32'h0000_8000, 32'h0000_FFFF,
               32'h1234_5678, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF, 32'hABCD_4000,
               32'h0000_C000, 32'h0012_3456};
        ds = '{16'h0000, 16'h0001, 16'h0002, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h4000,
               16'h1235, 16'hC000, 16'h00FF};
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(busy === 1'b0 && done === 1'b0, "R10 reset control", {busy, done}, 0);
        chk(quotient === 16'h0 && remainder === 16'h0, "R10 reset data", {quotient, remainder}, 0);
        chk(div_zero === 1'b0 && overflow === 1'b0, "R10 reset flags", {div_zero, overflow}, 0);
        rst_n = 1'b1;
        // R4 R5 R6 R7 R8 R9: corner sweep over every mode
        for (int m = 0; m < 8; m++)
            for (int i = 0; i < 12; i++)
                for (int j = 0; j < 10; j++)
                    run_div(dv[i], ds[j], m[0], m[1], m[2], (m == 0) ? 0 : 35, (i == 3 && j == 7));
        // R6: upper dividend half ignored in short integer mode
        run_div(32'hDEAD_0064, 16'h0007, 1'b0, 1'b0, 1'b0, 20, 1'b0);
        run_div(32'h5A5A_FF9C, 16'h0007, 1'b1, 1'b0, 1'b0, 20, 1'b0);
        // R7: signed fraction -0.5 / 0.5 gives exactly -1.0
        run_div(32'h0000_C000, 16'h4000, 1'b1, 1'b1, 1'b0, 10, 1'b0);
        // R1: start during busy is ignored
        for (int k = 0; k < 20; k++)
            run_div(32'h0000_1000 + k, 16'h0013 + k[15:0], k[0], 1'b0, k[1], 25, 1'b1);
        // R4 R5: random operands with in-range quotients
        for (int k = 0; k < 300; k++) begin
            logic [15:0] b;
            logic [31:0] a;
            b = $urandom[15:0] | 16'h0100;
            a = {($urandom[15:0] % b), $urandom[15:0]};
            run_div(a, b, 1'b0, 1'b0, 1'b1, 40, 1'b0);
            run_div($urandom, $urandom[15:0], 1'b1, $urandom[0:0], $urandom[0:0], 40, 1'b0);
        end
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule